// File: doc/BRIEF.md
# Self-Timed Byte-Write Nonvolatile Memory Controller

This block is the control core of a 2048 x 8 byte-writable nonvolatile memory that a host drives like a static RAM. It samples active-low chip-select, output-enable and write-strobe inputs, plus an 11-bit address and an 8-bit data bus, with a local clock through two-flop synchronizers. A host write fills only an address latch and a data latch. The address is taken when the later of the write strobe and chip select goes low, with output enable high. The data is taken when the earlier of the two goes high. That closing edge launches a self-timed internal cycle. The cycle erases the target byte to all ones, then programs the latched byte into a behavioural storage array.

While the internal cycle runs, the block asserts a pull-down enable that models an open-drain ready/busy line, so several devices can share one wired line. It ignores every strobe and keeps the data output disabled. A write is refused when output enable is low, chip select is high, the write strobe is high, the supply-low input is set, or the write-strobe low time is shorter than a programmable number of clock samples. Reads are plain level reads: chip select and output enable low with the write strobe high drive the stored byte out on a registered data path. The strobes carry no handshake, so there is no back-pressure path. A host that starts an access while the pull-down is asserted simply gets no response and must poll the flag.

Every strobe, address and data input crosses a `SYNC_STAGES`-deep register chain before use. Address and data must therefore be held for at least `SYNC_STAGES + 1` clock periods around the strobe edges that capture them. `ERASE_CYC + PROG_CYC` must not exceed 10 ms at the chosen clock. The defaults give exactly 10 ms at 250 MHz.

Top module: `nvbyte_ctrl`

## Requirements
- R1: With chip select low, output enable low and write strobe high while idle, `dout_en` is 1 and `dout` equals the byte stored at `addr`, within `SYNC_STAGES + 2` clock cycles.
- R2: `dout_en` is 0 whenever chip select or output enable has been high for `SYNC_STAGES + 1` cycles.
- R3: A write closed by the write strobe going high, and a write closed by chip select going high, each store `din` at `addr`, and a later read returns it.
- R4: Each accepted write holds `busy_pd` at 1 for exactly `ERASE_CYC + PROG_CYC` consecutive clock cycles, after which it returns to 0.
- R5: While `busy_pd` is 1, `dout_en` stays 0 even under read strobes, and a write attempted during that time neither starts a cycle nor changes any stored byte.
- R6: A write attempt with output enable low, or with chip select held high, starts no cycle and leaves the target byte unchanged.
- R7: A write-strobe low time of `WE_MIN_LOW - 1` clock periods starts no cycle. A low time of exactly `WE_MIN_LOW` periods starts one.
- R8: While `supply_low` is 1, a write attempt starts no cycle and leaves the target byte unchanged.
- R9: A write replaces the old byte in every bit, in both directions. The byte is erased to 8'hFF and then programmed, so a byte holding 8'h00 and then written with 8'hA5 reads 8'hA5.
- R10: After reset, `busy_pd` is 0 and `dout_en` is 0.
- R11: A write uses the address present when the later strobe fell, even if `addr` changes before the strobes rise. It stores the data present when the earlier strobe rose, even if `din` changed while the strobes were low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| supply_low | input | 1 | 1 while the supply is below the write-safe level |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the host |
| dout | output | DATA_W | Read data toward the pins |
| dout_en | output | 1 | Output driver enable; 0 means high impedance |
| busy_pd | output | 1 | Pull-down enable of the ready/busy line; 1 while an internal cycle runs |

## Verification
The bench builds the block with `ERASE_CYC = 20`, `PROG_CYC = 30` and `WE_MIN_LOW = 5`, keeping the full 11-bit address and 8-bit data widths. The short stage lengths let a run include many complete internal cycles, count each busy window exactly, and fit strobe activity inside one busy window. A filter length of five lets the bench drive pulses one sample below and exactly at the acceptance threshold.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ERASE = 2'd1,
    SQ_PROG  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_BIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= {W{RST_BIT}};
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nvb_strobe.sv
module nvb_strobe #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int WE_MIN_LOW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic              sl_s,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              start,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data
);
  localparam int CW = $clog2(WE_MIN_LOW + 1);

  logic [CW-1:0] low_run_q;
  logic          we_ok;
  logic          wr_act;
  logic          pending_q;
  logic          arm;
  logic          abort;
  logic          finish;

  // low_run_q counts earlier consecutive low samples of the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run_q <= '0;
    else if (we_s) low_run_q <= '0;
    else if (low_run_q < CW'(WE_MIN_LOW)) low_run_q <= low_run_q + 1'b1;
  end

  assign we_ok  = !we_s && (low_run_q >= CW'(WE_MIN_LOW - 1));
  assign wr_act = we_ok && !ce_s && oe_s && !sl_s && !busy;
  assign arm    = wr_act && !pending_q;
  assign abort  = pending_q && (!oe_s || sl_s);
  assign finish = pending_q && !abort && (!we_ok || ce_s);
  assign start  = finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
    end else if (arm) begin
      pending_q <= 1'b1;
      lat_addr  <= addr_s;
    end else if (abort) begin
      pending_q <= 1'b0;
    end else if (finish) begin
      pending_q <= 1'b0;
      lat_data  <= din_s;
    end
  end
endmodule

// File: rtl/nvb_seq.sv
module nvb_seq #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ERASE_CYC = 1250000,
  parameter int PROG_CYC  = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_data,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  import nvb_pkg::*;

  localparam int LONGEST = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  sq_state_t  state_q;
  logic [CNT_W-1:0] cnt_q;
  logic       erase_last;
  logic       prog_last;

  assign erase_last = (state_q == SQ_ERASE) && (cnt_q == CNT_W'(ERASE_CYC - 1));
  assign prog_last  = (state_q == SQ_PROG)  && (cnt_q == CNT_W'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_ERASE;
          cnt_q   <= '0;
        end
        SQ_ERASE: if (erase_last) begin
          state_q <= SQ_PROG;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        SQ_PROG: if (prog_last) begin
          state_q <= SQ_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  // erase writes all ones at launch; program writes the latch at the end
  assign arr_we    = (start && (state_q == SQ_IDLE)) || prog_last;
  assign arr_addr  = lat_addr;
  assign arr_wdata = prog_last ? lat_data : {DATA_W{1'b1}};
endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int ERASE_CYC   = 1250000,
  parameter int PROG_CYC    = 1250000,
  parameter int WE_MIN_LOW  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy_pd
);
  logic              ce_s, oe_s, we_s, sl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              start_w;
  logic              busy_w;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;
  logic              rd_ok;

  nvb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q({ce_s, oe_s, we_s})
  );

  nvb_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_sync_sl (
    .clk(clk), .rst_n(rst_n), .d(supply_low), .q(sl_s)
  );

  nvb_sync #(.W(ADDR_W + DATA_W), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q({addr_s, din_s})
  );

  nvb_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_MIN_LOW(WE_MIN_LOW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .sl_s(sl_s),
    .busy(busy_w), .addr_s(addr_s), .din_s(din_s), .start(start_w),
    .lat_addr(lat_addr), .lat_data(lat_data)
  );

  nvb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .lat_addr(lat_addr), .lat_data(lat_data),
    .busy(busy_w), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  nvb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .raddr(addr_s), .rdata(dout)
  );

  assign rd_ok = !ce_s && !oe_s && we_s && !busy_w && !start_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_en <= 1'b0;
    else dout_en <= rd_ok;
  end

  assign busy_pd = busy_w;
endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(
  parameter int TOTAL = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic busy_pd,
  input logic dout_en,
  input logic start,
  input logic busy,
  input logic oe_s,
  input logic sl_s
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy_pd) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_pd) |-> (run_q == 32'(TOTAL)));

  p_busy_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 32'(TOTAL));

  p_busy_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pd |-> !dout_en);

  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  p_start_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> oe_s);

  p_start_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !sl_s);

  p_ce_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n, 1) && $past(ce_n, 2) && $past(ce_n, 3)) |-> !dout_en);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_pd);
endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(.TOTAL(ERASE_CYC + PROG_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .busy_pd(busy_pd), .dout_en(dout_en),
  .start(start_w), .busy(busy_w), .oe_s(oe_s), .sl_s(sl_s)
);

// File: tb/test_nvbyte_ctrl.sv
`timescale 1ns/1ps
module test_nvbyte_ctrl;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int EC = 20;
  localparam int PC = 30;
  localparam int FL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy_pd;

  int n_chk = 0;
  int n_err = 0;
  int starts = 0;
  int last_len = 0;
  int run = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nvbyte_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(EC), .PROG_CYC(PC),
                .WE_MIN_LOW(FL), .SYNC_STAGES(2)) i_nvbyte_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .supply_low(supply_low), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .busy_pd(busy_pd)
  );

  always @(negedge clk) begin
    if (busy_pd) begin
      if (run == 0) starts++;
      run++;
    end else if (run != 0) begin
      last_len = run;
      run = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit ce_ctrl, input int low_cyc);
    addr = a; din = d; oe_n = 1'b1;
    cyc(1);
    if (!ce_ctrl) begin
      ce_n = 1'b0; cyc(2); we_n = 1'b0; cyc(low_cyc); we_n = 1'b1; cyc(2); ce_n = 1'b1;
    end else begin
      we_n = 1'b0; cyc(2); ce_n = 1'b0; cyc(low_cyc); ce_n = 1'b1; cyc(2); we_n = 1'b1;
    end
    cyc(4);
  endtask

  task automatic wait_idle();
    cyc(2);
    while (busy_pd) cyc(1);
    cyc(2);
  endtask

  task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    chk({tag, " dout_en"}, dout_en, 1);
    chk({tag, " dout"}, dout, exp);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(5);
  endtask

  task automatic t_reset();
    chk("R10 busy_pd after reset", busy_pd, 0);
    chk("R10 dout_en after reset", dout_en, 0);
  endtask

  task automatic t_we_write();
    drive_write(11'h123, 8'h5A, 0, FL + 3);
    wait_idle();
    chk("R4 busy length we-ctrl", last_len, EC + PC);
    chk("R4 busy released", busy_pd, 0);
    read_chk("R3 R1 we-ctrl read", 11'h123, 8'h5A);
  endtask

  task automatic t_ce_write();
    drive_write(11'h7FF, 8'hC3, 1, FL + 3);
    wait_idle();
    chk("R4 busy length ce-ctrl", last_len, EC + PC);
    read_chk("R3 ce-ctrl read", 11'h7FF, 8'hC3);
  endtask

  task automatic t_overwrite();
    drive_write(11'h0F0, 8'h00, 0, FL + 3); wait_idle();
    read_chk("R9 zero written", 11'h0F0, 8'h00);
    drive_write(11'h0F0, 8'hA5, 0, FL + 3); wait_idle();
    read_chk("R9 overwrite both directions", 11'h0F0, 8'hA5);
    drive_write(11'h0F0, 8'h5A, 1, FL + 3); wait_idle();
    read_chk("R9 overwrite inverse", 11'h0F0, 8'h5A);
  endtask

  task automatic t_hiz();
    addr = 11'h123; we_n = 1'b1;
    ce_n = 1'b0; oe_n = 1'b1; cyc(6);
    chk("R2 hiz oe high", dout_en, 0);
    ce_n = 1'b1; oe_n = 1'b0; cyc(6);
    chk("R2 hiz ce high", dout_en, 0);
    ce_n = 1'b1; oe_n = 1'b1; cyc(4);
  endtask

  task automatic t_addr_hold();
    drive_write(11'h055, 8'h11, 0, FL + 3); wait_idle();
    addr = 11'h200; din = 8'h3C; oe_n = 1'b1;
    cyc(1); ce_n = 1'b0; cyc(2); we_n = 1'b0; cyc(FL + 5);
    addr = 11'h055; cyc(4);
    we_n = 1'b1; cyc(2); ce_n = 1'b1; cyc(4);
    wait_idle();
    read_chk("R11 address from falling edge", 11'h200, 8'h3C);
    read_chk("R11 late address untouched", 11'h055, 8'h11);
  endtask

  task automatic t_data_late();
    addr = 11'h201; din = 8'h77; oe_n = 1'b1;
    cyc(1); we_n = 1'b0; cyc(2); ce_n = 1'b0; cyc(3);
    din = 8'h9E; cyc(FL + 4);
    ce_n = 1'b1; cyc(2); we_n = 1'b1; cyc(4);
    wait_idle();
    read_chk("R11 data from rising edge", 11'h201, 8'h9E);
  endtask

  task automatic t_oe_inhibit();
    int s0;
    s0 = starts;
    addr = 11'h123; din = 8'hEE; oe_n = 1'b0;
    cyc(1); ce_n = 1'b0; cyc(2); we_n = 1'b0; cyc(FL + 3); we_n = 1'b1; cyc(2);
    ce_n = 1'b1; oe_n = 1'b1; cyc(8);
    chk("R6 oe low no cycle", starts, s0);
    ce_n = 1'b1; we_n = 1'b0; cyc(FL + 3); we_n = 1'b1; cyc(8);
    chk("R6 ce high no cycle", starts, s0);
    read_chk("R6 byte unchanged", 11'h123, 8'h5A);
  endtask

  task automatic t_glitch();
    int s0;
    s0 = starts;
    drive_write(11'h123, 8'h01, 0, FL - 1);
    cyc(6);
    chk("R7 short pulse rejected", starts, s0);
    read_chk("R7 byte unchanged", 11'h123, 8'h5A);
    drive_write(11'h123, 8'h02, 0, FL);
    wait_idle();
    chk("R7 threshold pulse accepted", starts, s0 + 1);
    read_chk("R7 threshold write stored", 11'h123, 8'h02);
  endtask

  task automatic t_supply();
    int s0;
    s0 = starts;
    supply_low = 1'b1; cyc(4);
    drive_write(11'h7FF, 8'h10, 0, FL + 3);
    drive_write(11'h7FF, 8'h20, 1, FL + 3);
    cyc(6);
    chk("R8 supply low no cycle", starts, s0);
    supply_low = 1'b0; cyc(4);
    read_chk("R8 byte unchanged", 11'h7FF, 8'hC3);
  endtask

  task automatic t_busy_lock();
    int s0;
    drive_write(11'h300, 8'h42, 0, FL + 3);
    s0 = starts;
    chk("R5 busy during cycle", busy_pd, 1);
    addr = 11'h7FF; ce_n = 1'b0; oe_n = 1'b0; cyc(5);
    chk("R5 no read while busy", dout_en, 0);
    ce_n = 1'b1; oe_n = 1'b1; cyc(1);
    drive_write(11'h7FF, 8'h99, 0, FL + 3);
    chk("R5 still in first cycle", busy_pd, 1);
    wait_idle();
    cyc(6);
    chk("R5 no extra cycle", starts, s0);
    read_chk("R5 blocked write ignored", 11'h7FF, 8'hC3);
    read_chk("R5 first write stored", 11'h300, 8'h42);
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc(3);
        t_reset();
        t_we_write();
        t_ce_write();
        t_overwrite();
        t_hiz();
        t_addr_hold();
        t_data_late();
        t_oe_inhibit();
        t_glitch();
        t_supply();
        t_busy_lock();
        done = 1;
      end
      begin
        cyc(150000);
      end
    join_any
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule